// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple register bus and produces a system reset when software stops servicing it. It counts pulses of a slow time-base input toward a period chosen by a 4-bit code. The code steps through a set of periods that is not linear: half a second, whole seconds from one to six, and then two-second steps up to sixteen seconds. Software restarts the count by writing a fixed pattern to the restart register. Changes to the action and mode registers are accepted only when the write carries a 16-bit key in its upper half-word. A stray write therefore cannot disarm the watchdog, change its period or feed it.

The bus has no back-pressure. A write is taken in the cycle `bus_wr` is high. Read data is a combinational function of `bus_addr` and the stored fields, so it is valid in the same cycle. On expiry with the reset action selected, `sys_rst` goes high for `RST_CYCLES` clock cycles and the enable bit clears. Time is measured in `tick` pulses, with `TICKS_PER_HALF` pulses per half-second. A one-per-millisecond tick gives a default of 500.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, reads at offsets 0x10, 0x14 and 0x18 return 0, `sys_rst` is low and the watchdog is disabled.
- R2: A write to offset 0x14 (action) or 0x18 (mode) changes the register only when wdata[31:16] equals 0x16AA. Any other write to these offsets leaves the register unchanged.
- R3: Reads return the stored fields with every other bit zero:
  - offset 0x14 returns the action in bits 1:0;
  - offset 0x18 returns the enable flag in bit 0 and the period code in bits 7:4;
  - offset 0x10 and every unmapped offset return 0.
- R4: A write to offset 0x10 restarts the count from zero only when bit 0 is 1 and bits 12:1 equal 0xA57, that is wdata[12:0] = 0x14AF. Any other write to 0x10 has no effect.
- R5: The period in half-seconds is a function of the code:
  - code 0 gives 1;
  - codes 1 to 6 give twice the code;
  - codes 7, 8, 9 and 0xA give 16, 20, 24 and 28;
  - codes 0xB to 0xF give 32.

  Expiry occurs on the tick that completes period × `TICKS_PER_HALF` ticks since the count last restarted.
- R6: On expiry with action 01, `sys_rst` is high from the next cycle for exactly `RST_CYCLES` cycles. The enable bit reads 0 afterwards and the code is kept.
- R7: On expiry with any action other than 01, `sys_rst` stays low, the enable bit stays set and counting starts again from zero.
- R8: Every accepted mode write restarts the count from zero. A mode write with bit 0 clear stops the watchdog, and it then never expires.
- R9: A restart or accepted mode write in the same cycle as the expiring tick wins: no expiry occurs and the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse, one clock wide |
| bus_wr | input | 1 | Write strobe, always accepted |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sys_rst | output | 1 | System reset pulse |

## Verification
A wrong period decode or tick count shows up as `sys_rst` rising on the wrong tick, and so as a timing error at the first expiry. An enable, action or code register that took an unkeyed write shows up at once on the next read of that offset. It can also show up later as a missing pulse or as an extra pulse. A bad restart or write priority shows up as an expiry one period too early or too late. The reference model compares `sys_rst` and `bus_rdata` on every cycle, so any divergence appears in the cycle it happens.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int OFF_RESTART = 'h10;
  localparam int OFF_ACTION  = 'h14;
  localparam int OFF_MODE    = 'h18;

  localparam logic [15:0] WR_KEY      = 16'h16AA;
  localparam logic [11:0] FEED_MAGIC  = 12'hA57;
  localparam logic [12:0] FEED_WORD   = {FEED_MAGIC, 1'b1};
  localparam logic [1:0]  ACT_SYSRST  = 2'b01;

  localparam int MAX_HALVES = 32;

  typedef logic [3:0] tcode_t;
  typedef logic [1:0] action_t;

  // Period of a code, in half-second units.
  function automatic logic [5:0] code_halves(tcode_t c);
    if (c == 4'd0)
      return 6'd1;
    else if (c <= 4'd6)
      return {1'b0, c, 1'b0};
    else if (c <= 4'hA)
      return 6'd16 + {c - 4'd7, 2'b00};
    else
      return 6'd32;
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              expire_rst,
  output logic [31:0]       bus_rdata,
  output logic              en,
  output tcode_t            code,
  output action_t           action,
  output logic              cnt_clr
);

  logic keyed, hit_restart, hit_action, hit_mode;
  logic feed_ok, action_ok, mode_ok;
  logic wdata_unused;

  assign keyed       = (bus_wdata[31:16] == WR_KEY);
  assign hit_restart = (bus_addr == ADDR_W'(OFF_RESTART));
  assign hit_action  = (bus_addr == ADDR_W'(OFF_ACTION));
  assign hit_mode    = (bus_addr == ADDR_W'(OFF_MODE));

  assign feed_ok   = bus_wr && hit_restart && (bus_wdata[12:0] == FEED_WORD);
  assign action_ok = bus_wr && hit_action && keyed;
  assign mode_ok   = bus_wr && hit_mode && keyed;
  assign cnt_clr   = feed_ok || mode_ok;

  assign wdata_unused = ^bus_wdata[15:13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      action <= '0;
    end else if (action_ok) begin
      action <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      code <= '0;
    end else if (mode_ok) begin
      en   <= bus_wdata[0];
      code <= bus_wdata[7:4];
    end else if (expire_rst) begin
      en   <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_action)
      bus_rdata[1:0] = action;
    else if (hit_mode) begin
      bus_rdata[0]   = en;
      bus_rdata[7:4] = code;
    end
  end

  a_r2_action_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_action && !keyed) |=> $stable(action));

  a_r2_mode_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_mode && !keyed && !expire_rst) |=> ($stable(code) && $stable(en)));

  a_r6_expiry_disables: assert property (@(posedge clk) disable iff (!rst_n)
    expire_rst |=> !en);

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_HALF = 500
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   en,
  input  tcode_t code,
  input  logic   cnt_clr,
  output logic   expire
);

  localparam int CNT_W = $clog2(MAX_HALVES * TICKS_PER_HALF + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             last;

  assign limit  = CNT_W'(32'(code_halves(code)) * TICKS_PER_HALF);
  assign last   = (cnt == limit - CNT_W'(1));
  assign expire = en && tick && !cnt_clr && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_clr || !en) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end

  a_r5_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit);

  a_r8_idle_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt == '0));

endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_out
);

  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (fire) begin
      left <= RW'(RST_CYCLES);
    end else if (left != '0) begin
      left <= left - RW'(1);
    end
  end

  assign rst_out = (left != '0);

  a_r6_pulse_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rst_out);

  a_r6_pulse_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(fire));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int TICKS_PER_HALF = 500,
  parameter int RST_CYCLES     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst
);

  logic    en, cnt_clr, expire, expire_rst;
  tcode_t  code;
  action_t action;

  assign expire_rst = expire && (action == ACT_SYSRST);

  wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .expire_rst (expire_rst),
    .bus_rdata  (bus_rdata),
    .en         (en),
    .code       (code),
    .action     (action),
    .cnt_clr    (cnt_clr)
  );

  wdt_timer #(.TICKS_PER_HALF(TICKS_PER_HALF)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (en),
    .code    (code),
    .cnt_clr (cnt_clr),
    .expire  (expire)
  );

  wdt_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (expire_rst),
    .rst_out (sys_rst)
  );

  a_r9_write_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !$rose(sys_rst));

endmodule

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;

  localparam int AW  = 8;
  localparam int TPH = 2;
  localparam int RSC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          sys_rst;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 0;
  bit  rst_seen = 0;
  int  tdiv = 0;

  keyed_wdt #(.ADDR_W(AW), .TICKS_PER_HALF(TPH), .RST_CYCLES(RSC)) i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst(sys_rst)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  // Behavioural reference model.
  int m_act, m_en, m_code, m_cnt, m_rst;

  function automatic int halves(int c);
    if (c == 0) return 1;
    if (c <= 6) return 2 * c;
    if (c == 7) return 16;
    if (c == 8) return 20;
    if (c == 9) return 24;
    if (c == 10) return 28;
    return 32;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_en = 0; m_code = 0; m_cnt = 0; m_rst = 0;
    end else begin
      int  old_act;
      bit  keyed, feed, mwr, awr;
      old_act = m_act;
      keyed = (bus_wdata[31:16] == 16'h16AA);
      feed  = bus_wr && (bus_addr == 8'h10) && (bus_wdata[12:0] == 13'h14AF);
      awr   = bus_wr && (bus_addr == 8'h14) && keyed;
      mwr   = bus_wr && (bus_addr == 8'h18) && keyed;
      if (m_rst > 0) m_rst = m_rst - 1;
      if (awr) m_act = int'(bus_wdata[1:0]);
      if (mwr) begin
        m_en = int'(bus_wdata[0]); m_code = int'(bus_wdata[7:4]); m_cnt = 0;
      end else if (feed) begin
        m_cnt = 0;
      end else if (m_en != 0 && tick) begin
        if (m_cnt + 1 >= halves(m_code) * TPH) begin
          m_cnt = 0;
          if (old_act == 1) begin m_en = 0; m_rst = RSC; end
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
  end

  function automatic logic [31:0] model_rd(logic [AW-1:0] a);
    if (a == 8'h14) return 32'(m_act);
    if (a == 8'h18) return 32'((m_code << 4) | m_en);
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      if (sys_rst !== (m_rst > 0)) begin
        miscompares++;
        $display("FAIL R6 R9 per-cycle sys_rst: got %0b expected %0b at %0t", sys_rst, (m_rst > 0), $time);
      end
      vectors++;
      if (bus_rdata !== model_rd(bus_addr)) begin
        miscompares++;
        $display("FAIL R3 per-cycle rdata @%h: got %h expected %h", bus_addr, bus_rdata, model_rd(bus_addr));
      end
      if (sys_rst) rst_seen = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    vectors++;
    if (bus_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s read @%h: got %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic wait_expiry(output int ticks, output int width);
    bit seen = 0;
    ticks = 0; width = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      if (tick) ticks++;
      @(negedge clk);
      if (sys_rst) begin seen = 1; break; end
    end
    if (seen) begin
      width = 1;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (sys_rst) width++; else break;
      end
    end else begin
      ticks = -1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int t, w;
    int codes[6] = '{0, 3, 6, 8, 10, 15};
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk("R1 sys_rst after reset", int'(sys_rst), 0);
    rd(8'h10, 32'h0, "R1");
    rd(8'h14, 32'h0, "R1");
    rd(8'h18, 32'h0, "R1");

    // R2: keyed and unkeyed writes
    wr(8'h14, 32'h16AA_0001);
    rd(8'h14, 32'h1, "R2 keyed action");
    wr(8'h14, 32'h0000_0002);
    rd(8'h14, 32'h1, "R2 unkeyed action");
    wr(8'h14, 32'h16AB_0003);
    rd(8'h14, 32'h1, "R2 wrong key action");
    wr(8'h18, 32'h0000_00B1);
    rd(8'h18, 32'h0, "R2 unkeyed mode");
    rd(8'h1C, 32'h0, "R3 unmapped");

    // R3 field layout, then R5/R6 with code 7
    wr(8'h18, 32'h16AA_FF71);
    rd(8'h18, 32'h71, "R3 mode fields");
    wait_expiry(t, w);
    chk("R5 ticks for code 7", t - 0, 32 * 1 - 0 + 0 - 0);
    chk("R6 pulse width", w, RSC);
    rd(8'h18, 32'h70, "R6 enable cleared");

    // R5: other codes
    foreach (codes[k]) begin
      wr(8'h18, {16'h16AA, 8'h00, 4'(codes[k]), 4'h1});
      wait_expiry(t, w);
      chk($sformatf("R5 ticks for code %0d", codes[k]), t, halves(codes[k]) * TPH);
      chk("R6 pulse width", w, RSC);
    end

    // R4: valid feeds hold off expiry, invalid ones do not
    wr(8'h18, 32'h16AA_0011);
    rst_seen = 0;
    repeat (20) begin
      repeat (4) @(posedge clk);
      wr(8'h10, 32'hFFFF_14AF);
    end
    chk("R4 fed watchdog no reset", int'(rst_seen), 0);
    repeat (10) begin
      repeat (4) @(posedge clk);
      wr(8'h10, (rst_seen ? 32'h0 : 32'h0000_14AE));
    end
    chk("R4 bad feed ignored", int'(rst_seen), 1);
    repeat (10) @(posedge clk);

    // R7: non-reset action
    wr(8'h14, 32'h16AA_0002);
    wr(8'h18, 32'h16AA_0001);
    rst_seen = 0;
    repeat (100) @(posedge clk);
    chk("R7 no reset with action 2", int'(rst_seen), 0);
    rd(8'h18, 32'h1, "R7 enable kept");
    wr(8'h14, 32'h16AA_0000);
    repeat (60) @(posedge clk);
    chk("R7 no reset with action 0", int'(rst_seen), 0);

    // R8: mode rewrites restart, disable stops
    wr(8'h14, 32'h16AA_0001);
    wr(8'h18, 32'h16AA_0011);
    rst_seen = 0;
    repeat (10) begin
      repeat (4) @(posedge clk);
      wr(8'h18, 32'h16AA_0011);
    end
    chk("R8 mode rewrite restarts", int'(rst_seen), 0);
    wr(8'h18, 32'h16AA_0010);
    rst_seen = 0;
    repeat (60) @(posedge clk);
    chk("R8 disabled never expires", int'(rst_seen), 0);
    rd(8'h18, 32'h10, "R8 disabled mode");

    // R9: feed on the expiring tick wins
    wr(8'h18, 32'h16AA_0001);
    rst_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      if (tick) break;
    end
    @(posedge clk); #1;
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0000_14AF;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 feed beats expiring tick", int'(rst_seen), 0);
    repeat (20) @(posedge clk);
    chk("R9 count restarted then expired", int'(rst_seen), 1);

    repeat (5) @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule